// File: doc/BRIEF.md
# Host Control Port with Banked Matrix Registers

This block gives an external host an 8-bit parallel path into a bank of control registers and a window of read-only status bytes. The host never addresses a register directly. It first loads an internal register pointer through one address code, then moves data through a second address code. Each data access advances the pointer by one when chip select is released, so a run of registers can be streamed with a single pointer load. Advancing stops at the last control register, 0x3F.

Two copies of a nine-byte gain/offset set are held, at 0x17..0x1F and 0x27..0x2F. An external bank pin picks which copy drives the active-set output, so the host can prepare one copy while the other is in use. A reset controller decides when the rest of the chip's outputs may be enabled. Holding the reset pin low clears the registers and disables the outputs. On release, a run-mode bit in register 0 selects between running at once and waiting for the host to set a software release bit.

The bus state machine has states BUS_IDLE, BUS_WRITE and BUS_READ. BUS_IDLE goes to BUS_WRITE or BUS_READ on the first cycle that chip select is low, and the write takes effect on that edge. Either held state returns to BUS_IDLE once chip select is high, and that is where the pointer advances. The reset state machine has states RST_HOLD, RST_WAIT and RST_RUN. RST_HOLD is kept while the pin is low. On release it goes to RST_RUN if the run-mode bit is set and to RST_WAIT otherwise. RST_WAIT goes to RST_RUN once the release bit or the run-mode bit is set. RST_RUN falls back to RST_WAIT when both bits are clear.

Top module: `host_ctrl_port`

## Requirements
- R1: While host_cs_n is high, host_oe is low and neither the pointer nor any register changes, whatever host_rw, host_addr and host_wdata do.
- R2: host_oe is high only while host_cs_n is low and host_rw is high (read). A write is host_cs_n low with host_rw low, and it never drives host_oe.
- R3: host_addr code 0 writes or reads the register pointer. Code 1 writes or reads the register the pointer names. Codes 2 and 3 read as 0x00, and writes through them change nothing.
- R4: After a code-1 access, the pointer increments by one on the clock after host_cs_n returns high, but only if it is below 0x3F. At 0x3F or above it keeps its value. Code 0, 2 and 3 accesses do not advance it.
- R5: active_set byte i (bits 8i+7..8i) equals register 0x17+i when the bank_sel value sampled at the previous clock was 0, and register 0x27+i when it was 1, for i in 0..8.
- R6: Pointer values 0x40..0x4B read status_in byte (pointer-0x40). 0x4C..0xFF read 0x00. Writes at any pointer of 0x40 or above are ignored.
- R7: While rst_pin_n is low, outputs_en is low, the pointer is 0x00, and every control register reads zero except the run-mode bit, register 0 bit 6.
- R8: When rst_pin_n rises with register 0 bit 6 clear, outputs_en stays low until the host writes register 0 bit 7 (release) high, and rises the clock after that write.
- R9: When rst_pin_n rises with register 0 bit 6 set, outputs_en is high from the first clock after release.
- R10: While rst_pin_n is low, a code-1 write still lands at pointer 0x00, but only bit 6 (run mode) is kept. That bit survives the reset pin.
- R11: While running with bit 6 clear, writing register 0 with bit 7 clear drops outputs_en the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock; host signals are sampled on its rising edge |
| rst_pin_n | input | 1 | Active-low chip reset pin, synchronous |
| host_cs_n | input | 1 | Active-low chip select |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 2 | 0 = pointer, 1 = register data, 2/3 = unused |
| host_wdata | input | 8 | Write data from the host |
| host_rdata | output | 8 | Read data to the host |
| host_oe | output | 1 | Drive enable for host_rdata; low means the bus is released |
| bank_sel | input | 1 | Selects the active gain/offset copy |
| status_in | input | 96 | Twelve status bytes, byte 0 in bits 7..0 |
| ctrl_q | output | 512 | All 64 control registers, register n in bits 8n+7..8n |
| active_set | output | 72 | Nine bytes of the selected gain/offset copy |
| outputs_en | output | 1 | High when downstream outputs may be driven |

## Verification
The assertions assume a host that is synchronous to clk and holds host_cs_n high for at least one full cycle between accesses. They also assume that host_rw and host_addr stay steady while chip select is low. Under those assumptions, one access maps to exactly one BUS_IDLE exit. The stimulus keeps to this contract: every access is one low cycle and one high cycle, with changes made on the falling clock edge. bank_sel and status_in change only between accesses, and the reset pin is toggled only while chip select is high.

// File: rtl/host_ctrl_pkg.sv
package host_ctrl_pkg;
    localparam int DW         = 8;
    localparam int AW         = 8;
    localparam int NUM_CTRL   = 64;
    localparam int STAT_N     = 12;
    localparam int BANK_N     = 9;
    localparam int IDX_W      = $clog2(NUM_CTRL);
    localparam logic [AW-1:0] CTRL_TOP   = AW'(NUM_CTRL - 1);
    localparam logic [AW-1:0] STAT_BASE  = 8'h40;
    localparam int BANK0_BASE = 'h17;
    localparam int BANK1_BASE = 'h27;
    localparam int SRST_BIT   = 7;
    localparam int MODE_BIT   = 6;
    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;

    typedef enum logic [1:0] {BUS_IDLE, BUS_WRITE, BUS_READ} bus_state_t;
    typedef enum logic [1:0] {RST_HOLD, RST_WAIT, RST_RUN} rst_state_t;
endpackage

// File: rtl/hcp_bus_fsm.sv
module hcp_bus_fsm
    import host_ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_pin_n,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] ptr_q,
    output logic          wr_data_en
);
    bus_state_t state_q, state_d;
    logic       data_acc_q;
    logic       start, ptr_load, incr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            state_q    <= BUS_IDLE;
            data_acc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) data_acc_q <= (addr == SEL_DATA);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (!cs_n) state_d = rw ? BUS_READ : BUS_WRITE;
            BUS_WRITE: if (cs_n)  state_d = BUS_IDLE;
            BUS_READ:  if (cs_n)  state_d = BUS_IDLE;
            default:              state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start      = (state_q == BUS_IDLE) && !cs_n;
        wr_data_en = start && !rw && (addr == SEL_DATA);
        ptr_load   = start && !rw && (addr == SEL_PTR);
        incr       = (state_q != BUS_IDLE) && cs_n && data_acc_q && (ptr_q < CTRL_TOP);
    end

    always_ff @(posedge clk) begin
        if (!rst_pin_n)    ptr_q <= '0;
        else if (ptr_load) ptr_q <= wdata;
        else if (incr)     ptr_q <= ptr_q + AW'(1);
    end
endmodule

// File: rtl/hcp_regfile.sv
module hcp_regfile
    import host_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_pin_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        ptr,
    input  logic [DW-1:0]        wdata,
    input  logic                 bank_sel,
    input  logic [STAT_N*DW-1:0] status_in,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_CTRL*DW-1:0] ctrl_q,
    output logic [BANK_N*DW-1:0] active_set,
    output logic                 srst_bit,
    output logic                 mode_bit
);
    localparam logic [DW-1:0] MODE_MASK = DW'(1) << MODE_BIT;

    logic [DW-1:0] regs [NUM_CTRL];
    logic          mode_q;
    logic          bank_q;
    logic          in_ctrl;

    assign in_ctrl = (ptr <= CTRL_TOP);

    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            for (int i = 0; i < NUM_CTRL; i++) regs[i] <= '0;
            bank_q <= 1'b0;
        end else begin
            bank_q <= bank_sel;
            if (wr_en && in_ctrl) regs[ptr[IDX_W-1:0]] <= wdata;
        end
    end

    // run-mode bit is kept through the reset pin
    always_ff @(posedge clk) begin
        if (wr_en && (ptr == '0)) mode_q <= wdata[MODE_BIT];
    end

    generate
        for (genvar g = 0; g < NUM_CTRL; g++) begin : g_view
            if (g == 0) begin : g_r0
                assign ctrl_q[DW-1:0] = (regs[0] & ~MODE_MASK) | (mode_q ? MODE_MASK : '0);
            end else begin : g_rn
                assign ctrl_q[g*DW +: DW] = regs[g];
            end
        end
        for (genvar b = 0; b < BANK_N; b++) begin : g_bank
            assign active_set[b*DW +: DW] = bank_q ? regs[BANK1_BASE + b] : regs[BANK0_BASE + b];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (ptr == AW'(i)) rd_data = ctrl_q[i*DW +: DW];
        for (int j = 0; j < STAT_N; j++)
            if (ptr == STAT_BASE + AW'(j)) rd_data = status_in[j*DW +: DW];
    end

    assign srst_bit = regs[0][SRST_BIT];
    assign mode_bit = mode_q;
endmodule

// File: rtl/hcp_reset_ctl.sv
module hcp_reset_ctl
    import host_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_pin_n,
    input  logic srst_bit,
    input  logic mode_bit,
    output logic outputs_en
);
    rst_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_pin_n) state_q <= RST_HOLD;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_HOLD: state_d = mode_bit ? RST_RUN : RST_WAIT;
            RST_WAIT: if (srst_bit || mode_bit)   state_d = RST_RUN;
            RST_RUN:  if (!srst_bit && !mode_bit) state_d = RST_WAIT;
            default:  state_d = RST_HOLD;
        endcase
    end

    always_comb outputs_en = (state_q == RST_RUN);
endmodule

// File: rtl/host_ctrl_port.sv
module host_ctrl_port
    import host_ctrl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_pin_n,
    input  logic                   host_cs_n,
    input  logic                   host_rw,
    input  logic [1:0]             host_addr,
    input  logic [DW-1:0]          host_wdata,
    output logic [DW-1:0]          host_rdata,
    output logic                   host_oe,
    input  logic                   bank_sel,
    input  logic [STAT_N*DW-1:0]   status_in,
    output logic [NUM_CTRL*DW-1:0] ctrl_q,
    output logic [BANK_N*DW-1:0]   active_set,
    output logic                   outputs_en
);
    logic [AW-1:0] ptr_q;
    logic          wr_data_en;
    logic [DW-1:0] reg_rdata;
    logic          srst_bit, mode_bit;

    hcp_bus_fsm u_bus (
        .clk(clk), .rst_pin_n(rst_pin_n), .cs_n(host_cs_n), .rw(host_rw),
        .addr(host_addr), .wdata(host_wdata), .ptr_q(ptr_q), .wr_data_en(wr_data_en)
    );

    hcp_regfile u_regs (
        .clk(clk), .rst_pin_n(rst_pin_n), .wr_en(wr_data_en), .ptr(ptr_q),
        .wdata(host_wdata), .bank_sel(bank_sel), .status_in(status_in),
        .rd_data(reg_rdata), .ctrl_q(ctrl_q), .active_set(active_set),
        .srst_bit(srst_bit), .mode_bit(mode_bit)
    );

    hcp_reset_ctl u_rst (
        .clk(clk), .rst_pin_n(rst_pin_n), .srst_bit(srst_bit),
        .mode_bit(mode_bit), .outputs_en(outputs_en)
    );

    always_comb begin
        host_oe = !host_cs_n && host_rw;
        unique case (host_addr)
            SEL_PTR:  host_rdata = ptr_q;
            SEL_DATA: host_rdata = reg_rdata;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/host_ctrl_port_chk.sv
module host_ctrl_port_chk
    import host_ctrl_pkg::*;
(
    input logic                   clk,
    input logic                   rst_pin_n,
    input logic                   host_cs_n,
    input logic                   host_rw,
    input logic [1:0]             host_addr,
    input logic [DW-1:0]          host_rdata,
    input logic                   bank_sel,
    input logic [NUM_CTRL*DW-1:0] ctrl_q,
    input logic [BANK_N*DW-1:0]   active_set,
    input logic                   outputs_en,
    input logic [AW-1:0]          ptr_q,
    input logic                   srst_bit,
    input logic                   mode_bit
);
    p_cs_hi_ptr_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (host_cs_n && $past(host_cs_n)) |=> $stable(ptr_q));

    p_cs_hi_regs_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        host_cs_n |=> $stable(ctrl_q));

    p_addr_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!host_cs_n && host_rw && host_addr[1]) |-> (host_rdata == '0));

    p_ptr_sat_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (ptr_q >= CTRL_TOP && host_cs_n) |=> (ptr_q == $past(ptr_q)));

    p_bank0_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !bank_sel |=> (active_set == ctrl_q[BANK0_BASE*DW +: BANK_N*DW]));

    p_bank1_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
        bank_sel |=> (active_set == ctrl_q[BANK1_BASE*DW +: BANK_N*DW]));

    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!host_cs_n && !host_rw && host_addr == SEL_DATA && ptr_q >= STAT_BASE) |=> $stable(ctrl_q));

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!host_cs_n && host_rw && host_addr == SEL_DATA && ptr_q >= STAT_BASE + AW'(STAT_N))
        |-> (host_rdata == '0));

    p_wait_off_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!outputs_en && !srst_bit && !mode_bit) |=> !outputs_en);
endmodule

bind host_ctrl_port host_ctrl_port_chk chk_i (.*);

// File: tb/host_ctrl_port_tb_top.sv
module host_ctrl_port_tb_top;
    import host_ctrl_pkg::*;

    logic clk = 1'b0;
    logic rst_pin_n, host_cs_n, host_rw, bank_sel;
    logic [1:0] host_addr;
    logic [DW-1:0] host_wdata, host_rdata;
    logic host_oe, outputs_en;
    logic [STAT_N*DW-1:0] status_in;
    logic [NUM_CTRL*DW-1:0] ctrl_q;
    logic [BANK_N*DW-1:0] active_set;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    host_ctrl_port dut_i (.*);

    // {rw(1=read), addr, wdata, expected read}
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h17, 8'h00},
        {1'b0, 2'd1, 8'hA1, 8'h00},
        {1'b0, 2'd1, 8'hB2, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h19},
        {1'b0, 2'd0, 8'h17, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'hA1},
        {1'b1, 2'd1, 8'h00, 8'hB2},
        {1'b0, 2'd2, 8'h55, 8'h00},
        {1'b1, 2'd2, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h19},
        {1'b0, 2'd0, 8'h3E, 8'h00},
        {1'b0, 2'd1, 8'h77, 8'h00},
        {1'b0, 2'd1, 8'h88, 8'h00},
        {1'b0, 2'd1, 8'h99, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h3F},
        {1'b1, 2'd1, 8'h00, 8'h99}
    };

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access: one cycle with chip select low, one cycle high
    task automatic access(input logic rd, input logic [1:0] a, input logic [7:0] wd,
                          output logic [7:0] rdv, output logic oe);
        host_cs_n = 1'b0; host_rw = rd; host_addr = a; host_wdata = wd;
        @(negedge clk);
        rdv = host_rdata; oe = host_oe;
        host_cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] wd);
        logic [7:0] d; logic o;
        access(1'b0, a, wd, d, o);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        logic o;
        access(1'b1, a, 8'h00, d, o);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic o;
        rst_pin_n = 1'b0; host_cs_n = 1'b1; host_rw = 1'b1; host_addr = 2'd0;
        host_wdata = 8'h00; bank_sel = 1'b0;
        for (int i = 0; i < STAT_N; i++) status_in[i*8 +: 8] = 8'hC0 + 8'(i);
        repeat (3) @(negedge clk);
        check("R7 outputs off in reset", 72'(outputs_en), 72'(0));
        wr(2'd1, 8'h40);                  // R10: run-mode bit written while held
        rd(2'd1, d);
        check("R10 mode bit kept in reset", 72'(d), 72'h40);
        rd(2'd0, d);
        check("R7 pointer zero in reset", 72'(d), 72'h00);
        rst_pin_n = 1'b1;
        @(negedge clk);
        check("R9 immediate run", 72'(outputs_en), 72'(1));

        // table of accesses: R3 and R4
        for (int v = 0; v < NV; v++) begin
            access(VEC[v][18], VEC[v][17:16], VEC[v][15:8], d, o);
            if (VEC[v][18]) check($sformatf("R3/R4 vector %0d", v), 72'(d), 72'(VEC[v][7:0]));
        end
        check("R3 code 2 write ignored", 72'(ctrl_q[8'h19*8 +: 8]), 72'h00);

        // R2: drive enable only on reads
        access(1'b1, 2'd0, 8'h00, d, o);
        check("R2 oe on read", 72'(o), 72'(1));
        wr(2'd0, 8'h20);
        access(1'b0, 2'd1, 8'h5A, d, o);
        check("R2 no oe on write", 72'(o), 72'(0));

        // R1: idle bus activity changes nothing
        wr(2'd0, 8'h20);
        for (int k = 0; k < 3; k++) begin
            host_cs_n = 1'b1; host_rw = 1'b0; host_addr = 2'(k); host_wdata = 8'hEE;
            @(negedge clk);
            check("R1 bus released", 72'(host_oe), 72'(0));
        end
        rd(2'd0, d);
        check("R1 pointer unchanged", 72'(d), 72'h20);
        check("R1 register unchanged", 72'(ctrl_q[8'h20*8 +: 8]), 72'h5A);

        // R5: two banks
        wr(2'd0, 8'h17);
        for (int i = 0; i < BANK_N; i++) wr(2'd1, 8'h01 + 8'(i));
        wr(2'd0, 8'h27);
        for (int i = 0; i < BANK_N; i++) wr(2'd1, 8'h11 + 8'(i));
        check("R5 bank 0 set", 72'(active_set), 72'h090807060504030201);
        bank_sel = 1'b1;
        #1;
        check("R5 switch waits for edge", 72'(active_set), 72'h090807060504030201);
        @(negedge clk);
        check("R5 bank 1 set", 72'(active_set), 72'h191817161514131211);

        // R6: status window
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h12);
        rd(2'd1, d);
        check("R6 status byte 0", 72'(d), 72'hC0);
        wr(2'd0, 8'h4B);
        rd(2'd1, d);
        check("R6 status byte 11", 72'(d), 72'hCB);
        wr(2'd0, 8'h4C);
        rd(2'd1, d);
        check("R6 reserved low", 72'(d), 72'h00);
        wr(2'd0, 8'hFF);
        rd(2'd1, d);
        check("R6 reserved top", 72'(d), 72'h00);
        check("R6 status write ignored", 72'(ctrl_q[7:0]), 72'h40);

        // R11, R8: software release
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        check("R11 release cleared", 72'(outputs_en), 72'(0));
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h80);
        check("R8 release set", 72'(outputs_en), 72'(1));

        // R7 then R8 via the reset pin with run mode clear
        rst_pin_n = 1'b0;
        @(negedge clk);
        check("R7 outputs off", 72'(outputs_en), 72'(0));
        check("R7 registers cleared", 72'(ctrl_q == '0), 72'(1));
        rst_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 held off after release", 72'(outputs_en), 72'(0));
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h80);
        check("R8 enabled by host", 72'(outputs_en), 72'(1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule